// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block derives the serial clock of an I2C master from the system clock. A single 32-bit divisor word sets the two SCL phases on their own. The lower half gives the length of the low phase and the upper half gives the length of the high phase. Each count stands for a block of eight system clocks. One full SCL period is therefore 8·(low + high) system clocks. Software that wants a symmetric clock writes ceil(ceil(fclk/(8·fscl))/2) into both halves, which never exceeds the requested rate. Rates from 100 kHz up to 400 kHz are the intended range.

Next to the open-drain SCL drive, the block gives a byte engine single-cycle strobes:
- one at the middle of every low phase, where SDA may change;
- one at the middle of every high phase, where SDA is sampled.

The block also places bus START and STOP conditions on its own SDA pull-down. A slave that holds SCL low stretches the high phase, because the high-phase count only runs while SCL reads high. Driving the enable input low parks the bus idle and clears all state.

Top module: `scl_timing_gen`

## Requirements
- R1: With divisor bits [15:0] = L, every low phase (`scl_drive_low` = 1) lasts exactly 8·max(L,1) clock cycles.
- R2: With divisor bits [31:16] = H and SCL not held by another device, every high phase lasts exactly 8·max(H,1) clock cycles.
- R3: A divisor half of zero behaves as a half of one, so neither phase is ever empty.
- R4: `chg_stb` is a one-cycle pulse in every low phase. Counting the first low cycle as 0, it is high in cycle 4·max(L,1)+1, and it never occurs while SCL is released.
- R5: `smp_stb` is a one-cycle pulse in every high phase. Counting the first high cycle as 0 and with no stretching, it is high in cycle 4·max(H,1)+1. It occurs only while `scl_in` reads high.
- R6: Each cycle in which the block releases SCL but `scl_in` reads low is added to the high phase. Such a cycle also delays `smp_stb` by one cycle. The high phase cannot end while SCL is held low.
- R7: While `en` is low, all outputs stay low from the next cycle on and pending START/STOP requests are dropped. After `en` rises, the first SCL low phase begins after a full 8·max(H,1)-cycle high phase.
- R8: A `start_req` pulse makes `sda_drive_low` rise at the next `smp_stb`, in the same cycle as `smp_stb`, with a one-cycle `cond_done`. SDA then stays pulled low until the next `chg_stb`, where it is released.
- R9: A `stop_req` pulse makes `sda_drive_low` rise at the next `chg_stb`, while SCL is low, without `cond_done`. At the following `smp_stb` it falls, and `cond_done` pulses in that cycle.
- R10: While `rst` is high, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable; low parks the bus idle |
| div_word | input | 32 | [15:0] low-phase length, [31:16] high-phase length, in 8-clock units |
| scl_in | input | 1 | SCL line level, already synchronous to `clk` |
| start_req | input | 1 | One-cycle request for a START condition |
| stop_req | input | 1 | One-cycle request for a STOP condition |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low for a START or STOP condition |
| chg_stb | output | 1 | Middle of the low phase: SDA may change |
| smp_stb | output | 1 | Middle of the high phase: SDA is sampled |
| cond_done | output | 1 | One-cycle pulse when a START or STOP has been placed |

## Verification
The hardest situation to create is clock stretching. It needs a second device to keep SCL low after the block has released it, and the hold must start in a known cycle of the high phase. The bench models the wired line as the AND of the block's drive and its own hold signal. It raises the hold in the first high cycle and keeps it for a counted number of cycles. Both the high-phase length and the sample-strobe position must then move by exactly that count. A related hard case is a START request that is pending when the enable drops. The bench creates this by requesting just after a sample point and disabling before the next one, then checks that no condition appears after re-enable.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } scl_phase_e;

  typedef struct packed {
    logic low_mid;
    logic high_mid;
  } scl_evt_t;

endpackage

// File: rtl/div_half_clamp.sv
module div_half_clamp #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] len
);
  // a zero half would give an empty phase; stretch it to one unit
  always_comb begin
    len = (raw == '0) ? W'(1) : raw;
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_gen_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             scl_in,
  input  logic [DIV_W-1:0] n_low,
  input  logic [DIV_W-1:0] n_high,
  output scl_phase_e       phase,
  output scl_evt_t         evt
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX  = PRE_W'(PRESCALE - 1);
  localparam logic [PRE_W-1:0] PRE_HALF = PRE_W'(PRESCALE / 2);

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] unit_q;
  logic [DIV_W-1:0] n_cur;
  logic [PRE_W-1:0] mid_pre;
  logic             adv;
  logic             at_mid;
  logic             last_unit;

  always_comb begin
    n_cur     = (phase == PH_LOW) ? n_low : n_high;
    // low phase always runs; high phase freezes while the line is held low
    adv       = en && ((phase == PH_LOW) || scl_in);
    mid_pre   = n_cur[0] ? PRE_HALF : '0;
    at_mid    = (unit_q == (n_cur >> 1)) && (pre_q == mid_pre);
    last_unit = (unit_q >= (n_cur - DIV_W'(1)));
    evt.low_mid  = adv && at_mid && (phase == PH_LOW);
    evt.high_mid = adv && at_mid && (phase == PH_HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase  <= PH_HIGH;
      pre_q  <= '0;
      unit_q <= '0;
    end else if (adv) begin
      if (pre_q == PRE_MAX) begin
        pre_q <= '0;
        if (last_unit) begin
          unit_q <= '0;
          phase  <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
          unit_q <= unit_q + DIV_W'(1);
        end
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/scl_cond_ctl.sv
module scl_cond_ctl
  import scl_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     start_req,
  input  logic     stop_req,
  input  scl_evt_t evt,
  output logic     sda_low,
  output logic     done
);
  logic start_pend_q;
  logic stop_pend_q;
  logic stop_armed_q;
  logic serve_stop_arm;
  logic serve_stop_rel;
  logic serve_start;

  always_comb begin
    serve_stop_arm = evt.low_mid && stop_pend_q;
    serve_stop_rel = evt.high_mid && stop_armed_q;
    serve_start    = evt.high_mid && !stop_armed_q && start_pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
      stop_armed_q <= 1'b0;
      sda_low      <= 1'b0;
      done         <= 1'b0;
    end else begin
      start_pend_q <= (start_pend_q && !serve_start) || start_req;
      stop_pend_q  <= (stop_pend_q && !serve_stop_arm) || stop_req;
      stop_armed_q <= (stop_armed_q && !serve_stop_rel) || serve_stop_arm;
      done         <= serve_stop_rel || serve_start;
      if (evt.low_mid) begin
        // pull low to prepare STOP, otherwise hand SDA back after START
        sda_low <= serve_stop_arm;
      end else if (serve_stop_rel) begin
        sda_low <= 1'b0;
      end else if (serve_start) begin
        sda_low <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PRESCALE = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [2*DIV_W-1:0]   div_word,
  input  logic                 scl_in,
  input  logic                 start_req,
  input  logic                 stop_req,
  output logic                 scl_drive_low,
  output logic                 sda_drive_low,
  output logic                 chg_stb,
  output logic                 smp_stb,
  output logic                 cond_done
);
  localparam int HALVES = 2;

  logic [DIV_W-1:0] half_len [HALVES];
  scl_phase_e       phase;
  scl_evt_t         evt;

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    div_half_clamp #(.W(DIV_W)) u_clamp (
      .raw (div_word[g*DIV_W +: DIV_W]),
      .len (half_len[g])
    );
  end

  scl_phase_ctr #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .scl_in (scl_in),
    .n_low  (half_len[0]),
    .n_high (half_len[1]),
    .phase  (phase),
    .evt    (evt)
  );

  scl_cond_ctl u_cond (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .start_req (start_req),
    .stop_req  (stop_req),
    .evt       (evt),
    .sda_low   (sda_drive_low),
    .done      (cond_done)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      chg_stb <= 1'b0;
      smp_stb <= 1'b0;
    end else begin
      chg_stb <= evt.low_mid;
      smp_stb <= evt.high_mid;
    end
  end

  assign scl_drive_low = (phase == PH_LOW);
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic scl_in,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic chg_stb,
  input logic smp_stb,
  input logic cond_done
);
  p_chg_in_low_r4: assert property (@(posedge clk) disable iff (rst)
    chg_stb |-> scl_drive_low);

  p_smp_in_high_r5: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> (!scl_drive_low && scl_in));

  p_hold_stretch_r6: assert property (@(posedge clk) disable iff (rst)
    (!scl_drive_low && !scl_in) |=> !scl_drive_low);

  p_disable_release_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_drive_low && !sda_drive_low && !chg_stb && !smp_stb && !cond_done));

  p_done_at_smp_r8: assert property (@(posedge clk) disable iff (rst)
    cond_done |-> smp_stb);

  p_sda_edges_r9: assert property (@(posedge clk) disable iff (rst)
    (sda_drive_low != $past(sda_drive_low)) |-> (chg_stb || smp_stb || !$past(en)));

  always_comb begin
    if (!rst) begin
      p_strobe_excl_r4: assert (!(chg_stb && smp_stb));
    end
  end
endmodule

bind scl_timing_gen scl_timing_chk u_chk (.*);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] div_word = 32'h0002_0002;
  logic        hold = 1'b0;
  logic        start_req = 1'b0;
  logic        stop_req = 1'b0;
  logic        scl_line;
  logic        scl_drive_low, sda_drive_low, chg_stb, smp_stb, cond_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  assign scl_line = !(scl_drive_low || hold);

  scl_timing_gen dut (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .div_word      (div_word),
    .scl_in        (scl_line),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .chg_stb       (chg_stb),
    .smp_stb       (smp_stb),
    .cond_done     (cond_done)
  );

  // {low half, high half, stretch cycles}
  localparam logic [47:0] VEC [6] = '{
    {16'd1, 16'd1, 16'd0},
    {16'd2, 16'd3, 16'd0},
    {16'd5, 16'd2, 16'd3},
    {16'd0, 16'd4, 16'd0},
    {16'd3, 16'd0, 16'd7},
    {16'd6, 16'd6, 16'd20}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_period(input int st, output int lo, output int hi,
                            output int ca, output int sa);
    lo = 0; hi = 0; ca = -1; sa = -1;
    @(negedge clk);
    while (scl_drive_low) @(negedge clk);
    while (!scl_drive_low) @(negedge clk);
    while (scl_drive_low) begin
      if (chg_stb) ca = lo;
      lo++;
      @(negedge clk);
    end
    while (!scl_drive_low) begin
      hold = (hi < st);
      if (smp_stb) sa = hi;
      hi++;
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  task automatic wait_smp();
    @(negedge clk);
    while (!smp_stb) @(negedge clk);
  endtask

  task automatic wait_chg();
    @(negedge clk);
    while (!chg_stb) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lo, hi, ca, sa, nl, nh, st, cnt, seen;
    repeat (3) @(negedge clk);
    // R10: reset state
    check({scl_drive_low, sda_drive_low, chg_stb, smp_stb, cond_done} == 5'b0,
          "R10", int'({scl_drive_low, sda_drive_low, chg_stb, smp_stb, cond_done}), 0);
    rst = 1'b0;
    en  = 1'b1;

    // R1..R6: vector table
    for (int v = 0; v < 6; v++) begin
      div_word = {VEC[v][31:16], VEC[v][47:32]};
      st = int'(VEC[v][15:0]);
      nl = (VEC[v][47:32] == 16'd0) ? 1 : int'(VEC[v][47:32]);
      nh = (VEC[v][31:16] == 16'd0) ? 1 : int'(VEC[v][31:16]);
      run_period(st, lo, hi, ca, sa);
      check(lo == 8*nl, "R1/R3 low length", lo, 8*nl);
      check(hi == 8*nh + st, "R2/R3/R6 high length", hi, 8*nh + st);
      check(ca == 4*nl + 1, "R4 change strobe", ca, 4*nl + 1);
      check(sa == 4*nh + 1 + st, "R5/R6 sample strobe", sa, 4*nh + 1 + st);
    end

    // R8: START condition
    div_word = 32'h0002_0002;
    run_period(0, lo, hi, ca, sa);
    wait_smp();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    while (!smp_stb) begin
      check(!cond_done && !sda_drive_low, "R8 early", int'(sda_drive_low), 0);
      @(negedge clk);
    end
    check(sda_drive_low && cond_done && !scl_drive_low, "R8 start placed",
          int'({sda_drive_low, cond_done}), 3);
    cnt = 0;
    @(negedge clk);
    while (!chg_stb) begin
      if (!sda_drive_low) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R8 SDA held", cnt, 0);
    check(!sda_drive_low, "R8 release at change", int'(sda_drive_low), 0);

    // R9: STOP condition
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    wait_chg();
    check(sda_drive_low && scl_drive_low && !cond_done, "R9 stop armed",
          int'({sda_drive_low, scl_drive_low, cond_done}), 6);
    wait_smp();
    check(!sda_drive_low && cond_done, "R9 stop placed",
          int'({sda_drive_low, cond_done}), 1);

    // R7: disable drops pending START and parks the bus
    wait_smp();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    en = 1'b0;
    seen = 0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      if (scl_drive_low || sda_drive_low || chg_stb || smp_stb || cond_done) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R7 parked outputs", seen, 0);
    div_word = 32'h0003_0002;
    en = 1'b1;
    cnt = 0;
    @(negedge clk);
    while (!scl_drive_low) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == 8*3 - 1, "R7 first high after enable", cnt, 8*3 - 1);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (cond_done || sda_drive_low) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R7 pending start dropped", seen, 0);

    // R10: reset while running
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({scl_drive_low, sda_drive_low, chg_stb, smp_stb, cond_done} == 5'b0,
          "R10 reset mid-run",
          int'({scl_drive_low, sda_drive_low, chg_stb, smp_stb, cond_done}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule